// File: doc/BRIEF.md
# Root Port Status and Control Register

This block is the 32-bit status and control word for one host root port. It sits on a plain register bus made of an address, a write strobe, write data and read data. The word answers at one decoded address, 0x440 by default. Port-side hardware feeds it five live status inputs: device attached, port enabled, overcurrent, the two data-line levels and the attached device's speed. The block registers these inputs so software can read them. It keeps a sticky change flag for the attached, enabled and overcurrent bits.

Software acknowledges a change flag by writing 1 to it. The same write-1 convention, applied to the enabled bit, asks the port logic to disable the port. Power, reset, resume, suspend and a 4-bit test selector are ordinary software-written bits, driven straight out to the port logic. A single port interrupt goes high whenever any change flag is set and the interrupt mask input is 1.

Top module: `root_port_csr`

## Requirements
- R1: The word reads at `bus_addr == CSR_ADDR` (default 0x440). Any other address reads 0, and a write there changes nothing. Bits 9 and 31:19 always read 0.
- R2: Bit 0 (attached), bit 4 (overcurrent), bits 11:10 (line levels) and bits 18:17 (speed: 00 high, 01 full, 10 low) show the matching input as registered at the previous clock edge. Software writes to these bits have no effect.
- R3: A change flag sets at the clock edge where its status input differs from the registered value. The flags are bit 1 for attached, bit 3 for enabled and bit 5 for overcurrent. A set flag stays set until it is cleared.
- R4: Writing 1 to a change-flag bit clears that flag. Writing 0 to it leaves the flag as it was.
- R5: Bit 2 shows the registered hardware enable input. Writing 1 to bit 2 raises `port_disable` for exactly the next cycle. Writing 0 to bit 2 leaves `port_disable` low.
- R6: `port_irq` is 1 exactly when `port_irq_mask` is 1 and at least one change flag is set.
- R7: Bit 6 (resume), bit 7 (suspend), bit 8 (port reset) and bit 12 (power) are read/write. Each drives its output from the cycle after the write.
- R8: Bits 16:13 are read/write test-control storage and drive `port_test`.
- R9: If a status input changes in the same cycle that software writes 1 to its flag, the flag ends up set.
- R10: Synchronous reset clears every software bit and every change flag. It also loads the current status inputs as the baseline, so a status that is present during reset raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational on address) |
| hw_attached | input | 1 | Device attached status |
| hw_enabled | input | 1 | Port enabled status |
| hw_overcurrent | input | 1 | Overcurrent status |
| hw_line | input | 2 | Data-line levels |
| hw_speed | input | 2 | Attached device speed |
| port_irq_mask | input | 1 | Port interrupt enable |
| port_irq | output | 1 | Port interrupt |
| port_power | output | 1 | Port power control |
| port_reset | output | 1 | Port reset control |
| port_resume | output | 1 | Resume signalling control |
| port_suspend | output | 1 | Suspend control |
| port_test | output | 4 | Test-control selector |
| port_disable | output | 1 | One-cycle disable request |

## Verification
Status inputs are changed one at a time and two at a time. This separates the flag bits from one another and shows whether each flag is sticky across idle cycles. Writes carry all-ones, all-zeros and single-bit patterns. These show that write-1-clear acts only on the addressed flag, and that the read-only fields and the enable bit do not take write data. A status change made in the same cycle as a write-1 clear of its flag shows which of the two wins. Writes and reads at a neighbouring address show the address decode.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

    localparam int WORD_W  = 32;
    localparam int N_TRACK = 3;

    // Bit positions of the register word (decoded by software)
    localparam int B_CONN   = 0;
    localparam int B_CONN_F = 1;
    localparam int B_EN     = 2;
    localparam int B_EN_F   = 3;
    localparam int B_OC     = 4;
    localparam int B_OC_F   = 5;
    localparam int B_RESUME = 6;
    localparam int B_SUSP   = 7;
    localparam int B_RST    = 8;
    localparam int B_LINE   = 10;
    localparam int B_POWER  = 12;
    localparam int B_TEST   = 13;
    localparam int B_SPEED  = 17;
    localparam int TEST_W   = 4;

    typedef struct packed {
        logic [1:0] speed;
        logic [1:0] line;
        logic       oc;
        logic       en;
        logic       conn;
    } hw_stat_t;

    typedef struct packed {
        logic [TEST_W-1:0] test;
        logic              power;
        logic              prst;
        logic              susp;
        logic              resume;
    } sw_ctrl_t;

    // flags ordering: [0]=attached, [1]=enabled, [2]=overcurrent
    function automatic logic [WORD_W-1:0] build_word(input hw_stat_t s,
                                                     input logic [N_TRACK-1:0] f,
                                                     input sw_ctrl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[B_CONN]                 = s.conn;
        w[B_CONN_F]               = f[0];
        w[B_EN]                   = s.en;
        w[B_EN_F]                 = f[1];
        w[B_OC]                   = s.oc;
        w[B_OC_F]                 = f[2];
        w[B_RESUME]               = c.resume;
        w[B_SUSP]                 = c.susp;
        w[B_RST]                  = c.prst;
        w[B_LINE +: 2]            = s.line;
        w[B_POWER]                = c.power;
        w[B_TEST +: TEST_W]       = c.test;
        w[B_SPEED +: 2]           = s.speed;
        return w;
    endfunction

endpackage

// File: rtl/rpc_change_tracker.sv
module rpc_change_tracker #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] live,
    input  logic [N-1:0] clr,
    output logic [N-1:0] level_q,
    output logic [N-1:0] flag_q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                level_q[i] <= live[i];
                flag_q[i]  <= 1'b0;
            end else begin
                level_q[i] <= live[i];
                if (live[i] != level_q[i])
                    flag_q[i] <= 1'b1;
                else if (clr[i])
                    flag_q[i] <= 1'b0;
            end
        end

        AST_FLAG_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
            (live[i] != level_q[i]) |=> flag_q[i]);                          // R3
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
            (flag_q[i] && !clr[i]) |=> flag_q[i]);                           // R3
        AST_FLAG_W1C: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && live[i] == level_q[i]) |=> !flag_q[i]);               // R4
        AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && live[i] != level_q[i]) |=> flag_q[i]);                // R9
    end

endmodule

// File: rtl/rpc_sw_ctrl.sv
module rpc_sw_ctrl
    import rpc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_hit,
    input  sw_ctrl_t wr_val,
    input  logic     wr_dis,
    output sw_ctrl_t ctrl_q,
    output logic     dis_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            dis_q  <= 1'b0;
        end else begin
            if (wr_hit)
                ctrl_q <= wr_val;
            dis_q <= wr_hit && wr_dis;
        end
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(ctrl_q));                                        // R7
    AST_DIS_PULSE: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && wr_dis) |=> dis_q);                                       // R5
    AST_DIS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(wr_hit && wr_dis) |=> !dis_q);                                     // R5

endmodule

// File: rtl/root_port_csr.sv
module root_port_csr
    import rpc_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 12'h440
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              hw_attached,
    input  logic              hw_enabled,
    input  logic              hw_overcurrent,
    input  logic [1:0]        hw_line,
    input  logic [1:0]        hw_speed,
    input  logic              port_irq_mask,
    output logic              port_irq,
    output logic              port_power,
    output logic              port_reset,
    output logic              port_resume,
    output logic              port_suspend,
    output logic [3:0]        port_test,
    output logic              port_disable
);

    logic               hit;
    logic               wr_hit;
    logic [N_TRACK-1:0] live_v;
    logic [N_TRACK-1:0] clr_v;
    logic [N_TRACK-1:0] level_v;
    logic [N_TRACK-1:0] flags;
    logic [1:0]         line_q;
    logic [1:0]         speed_q;
    hw_stat_t           stat;
    sw_ctrl_t           wr_val;
    sw_ctrl_t           ctrl;
    logic               unused_wdata;

    assign hit    = (bus_addr == CSR_ADDR);
    assign wr_hit = hit && bus_wr;

    assign live_v = {hw_overcurrent, hw_enabled, hw_attached};
    assign clr_v  = wr_hit ? {bus_wdata[B_OC_F], bus_wdata[B_EN_F], bus_wdata[B_CONN_F]}
                           : '0;

    rpc_change_tracker #(.N(N_TRACK)) u_track (
        .clk     (clk),
        .rst     (rst),
        .live    (live_v),
        .clr     (clr_v),
        .level_q (level_v),
        .flag_q  (flags)
    );

    always_ff @(posedge clk) begin
        line_q  <= hw_line;
        speed_q <= hw_speed;
    end

    always_comb begin
        wr_val.resume = bus_wdata[B_RESUME];
        wr_val.susp   = bus_wdata[B_SUSP];
        wr_val.prst   = bus_wdata[B_RST];
        wr_val.power  = bus_wdata[B_POWER];
        wr_val.test   = bus_wdata[B_TEST +: TEST_W];
    end

    rpc_sw_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (wr_hit),
        .wr_val (wr_val),
        .wr_dis (bus_wdata[B_EN]),
        .ctrl_q (ctrl),
        .dis_q  (port_disable)
    );

    always_comb begin
        stat.conn  = level_v[0];
        stat.en    = level_v[1];
        stat.oc    = level_v[2];
        stat.line  = line_q;
        stat.speed = speed_q;
    end

    assign bus_rdata    = hit ? build_word(stat, flags, ctrl) : '0;
    assign port_irq     = port_irq_mask && (|flags);
    assign port_power   = ctrl.power;
    assign port_reset   = ctrl.prst;
    assign port_resume  = ctrl.resume;
    assign port_suspend = ctrl.susp;
    assign port_test    = ctrl.test;

    assign unused_wdata = ^{bus_wdata[31:17], bus_wdata[11:9], bus_wdata[B_OC], bus_wdata[B_CONN]};

    AST_IRQ_FROM_FLAG: assert property (@(posedge clk) disable iff (rst)
        $rose(port_irq) |-> (port_irq_mask && flags != '0));                 // R6
    AST_RO_ATTACH: assert property (@(posedge clk) disable iff (rst)
        hit |-> (bus_rdata[B_CONN] == level_v[0]));                          // R2

endmodule

// File: tb/sim_root_port_csr.sv
module sim_root_port_csr;

    localparam logic [11:0] CSR = 12'h440;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = CSR;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        hw_attached = 1'b1, hw_enabled = 1'b1, hw_overcurrent = 1'b0;
    logic [1:0]  hw_line = 2'b10, hw_speed = 2'b01;
    logic        port_irq_mask = 1'b1;
    logic        port_irq, port_power, port_reset, port_resume, port_suspend, port_disable;
    logic [3:0]  port_test;

    always #4 clk = ~clk;

    root_port_csr u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_attached(hw_attached), .hw_enabled(hw_enabled),
        .hw_overcurrent(hw_overcurrent), .hw_line(hw_line), .hw_speed(hw_speed),
        .port_irq_mask(port_irq_mask), .port_irq(port_irq),
        .port_power(port_power), .port_reset(port_reset),
        .port_resume(port_resume), .port_suspend(port_suspend),
        .port_test(port_test), .port_disable(port_disable)
    );

    typedef struct {
        int          kind;   // 0 read word, 1 irq, 2 disable, 3 control outputs
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference model state
    logic       m_conn, m_en, m_oc;
    logic [1:0] m_line, m_speed;
    logic [2:0] m_flag;
    logic       m_res, m_sus, m_rst, m_pw;
    logic [3:0] m_test;

    function automatic logic [31:0] model_word();
        logic [31:0] w;
        w = '0;
        w[0] = m_conn; w[1] = m_flag[0]; w[2] = m_en; w[3] = m_flag[1];
        w[4] = m_oc; w[5] = m_flag[2]; w[6] = m_res; w[7] = m_sus; w[8] = m_rst;
        w[11:10] = m_line; w[12] = m_pw; w[16:13] = m_test; w[18:17] = m_speed;
        return w;
    endfunction

    task automatic push(input int kind, input logic [31:0] exp, input string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    task automatic expect_word(input string req);
        push(0, model_word(), req);
    endtask

    // monitor: compares pending items against outputs just after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.kind)
                    0:       act = bus_rdata;
                    1:       act = {31'b0, port_irq};
                    2:       act = {31'b0, port_disable};
                    default: act = {24'b0, port_test, port_power, port_reset,
                                     port_suspend, port_resume};
                endcase
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        if (a == CSR) begin
            for (int i = 0; i < 3; i++)
                if (d[1 + 2*i]) m_flag[i] = 1'b0;
            m_res = d[6]; m_sus = d[7]; m_rst = d[8]; m_pw = d[12]; m_test = d[16:13];
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = CSR; bus_wdata = '0;
    endtask

    task automatic drive_hw(input logic c, input logic e, input logic o,
                            input logic [1:0] l, input logic [1:0] s);
        @(negedge clk);
        hw_attached = c; hw_enabled = e; hw_overcurrent = o; hw_line = l; hw_speed = s;
        if (c != m_conn) m_flag[0] = 1'b1;
        if (e != m_en)   m_flag[1] = 1'b1;
        if (o != m_oc)   m_flag[2] = 1'b1;
        m_conn = c; m_en = e; m_oc = o; m_line = l; m_speed = s;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        m_conn = 1; m_en = 1; m_oc = 0; m_line = 2'b10; m_speed = 2'b01;
        m_flag = '0; m_res = 0; m_sus = 0; m_rst = 0; m_pw = 0; m_test = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: baseline captured, no flags, controls cleared
        expect_word("R10 reset word");
        push(1, 0, "R10 no irq after reset");
        push(3, 0, "R10 controls cleared");

        // R7 R8 R2 R1: all-ones write
        bus_write(CSR, 32'hFFFF_FFFF);
        expect_word("R7 R8 R2 R1 all-ones write");
        push(3, {24'b0, 4'hF, 4'hF}, "R7 R8 control outputs");
        push(2, 1, "R5 disable pulse on write 1");
        @(negedge clk);
        push(2, 0, "R5 disable pulse lasts one cycle");
        expect_word("R5 enabled still follows hardware");

        bus_write(CSR, 32'h0000_0000);
        push(2, 0, "R5 write 0 no disable");
        push(3, 0, "R7 controls written low");
        expect_word("R4 zero write keeps state");

        // R3 R6: attach drops
        drive_hw(0, 1, 0, 2'b10, 2'b01);
        expect_word("R3 attach change flag");
        push(1, 1, "R6 irq with mask");
        @(negedge clk); port_irq_mask = 1'b0;
        #2 push(1, 0, "R6 irq masked");
        repeat (3) @(negedge clk);
        expect_word("R3 flag sticky while idle");
        port_irq_mask = 1'b1;

        // R4
        bus_write(CSR, 32'h0000_0028);
        expect_word("R4 other flag bits do not clear attach flag");
        bus_write(CSR, 32'h0000_0002);
        expect_word("R4 write 1 clears attach flag");
        push(1, 0, "R6 no irq with no flags");

        // R3 R2: two changes at once, plus line/speed
        drive_hw(0, 0, 1, 2'b11, 2'b10);
        expect_word("R3 R2 enable and overcurrent flags, low speed");
        bus_write(CSR, 32'h0000_0008);
        expect_word("R4 clears only enabled flag");

        // R9: change overcurrent while clearing its flag
        @(negedge clk);
        hw_overcurrent = 1'b0; bus_addr = CSR; bus_wr = 1'b1; bus_wdata = 32'h0000_0020;
        m_oc = 1'b0; m_flag[2] = 1'b1;
        m_res = 0; m_sus = 0; m_rst = 0; m_pw = 0; m_test = 0;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        expect_word("R9 set beats clear");
        bus_write(CSR, 32'h0000_0020);
        expect_word("R4 overcurrent flag cleared");

        // R2: writes to hardware-only fields
        bus_write(CSR, 32'h0006_0C11);
        expect_word("R2 read-only fields ignore write");

        // R1: other address
        @(negedge clk);
        bus_addr = 12'h444;
        push(0, 0, "R1 other address reads zero");
        bus_write(12'h444, 32'h0001_F1C0);
        expect_word("R1 other-address write ignored");
        push(3, 0, "R1 controls unchanged by other address");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule